// File: doc/BRIEF.md
# ATA Data Port Write-Posting and Read-Ahead Buffer

This block sits on one ATA channel, between the host request port and the PIO cycle sequencer. For writes to the data port it posts the data into a small FIFO and completes the host access at once. The device write cycles then drain to the sequencer later, in the order the writes arrived. For reads of the data port it fetches ahead: the first read of a run is a demand read and waits for the device. When that read completes, the block starts the next device read at the same width on its own. The following host read of that width is then served from the held word with no device latency, and each such hit starts another read-ahead.

Posting and read-ahead are each enabled per drive. Any access that is not a data-port access of this channel stalls until the posting FIFO has drained. Examples are a task-file register access or an access routed to the other channel. A write, an unrelated access, a read of the other width or the stop input throws away held read-ahead data. A read-ahead already issued to the sequencer still completes, and its data is then dropped.

Both ports use a request/acknowledge handshake. An access completes in the cycle where request and acknowledge are both high, and the requester holds its fields stable until then.

Top module: `ataPostBuf`

## Requirements
- R1: Out of reset, seqReq and hostAck are low and neither the posting FIFO nor the read-ahead holds anything.
- R2: A data-port write (hostDataPort=1, hostChan=0, hostWrite=1) to a drive whose postEn bit is 1 is acknowledged in the cycle it is presented while the FIFO is not full. Afterwards, exactly one sequencer write is issued with the same data, width and drive.
- R3: The posting FIFO holds DEPTH (default 4) writes. A posted write that arrives while the FIFO is full is held unacknowledged until an entry drains. Entries reach the sequencer in arrival order.
- R4: A data-port write to a drive whose postEn bit is 0, and any unrelated access, is passed to the sequencer. It is acknowledged only in the cycle the sequencer completes it.
- R5: An unrelated access (hostDataPort=0, or hostChan=1) is not presented to the sequencer while the FIFO holds any entry. It follows after every earlier posted write.
- R6: A data-port read with no held read-ahead is a demand read. It goes to the sequencer at the host's width (hostWide=1 means 32 bits, 0 means 16 bits), and the host is acknowledged with the sequencer's read data.
- R7: After a demand read to a drive whose prefEn bit is 1, a sequencer read at the demand width and drive is issued with no host request. The next host data-port read of that width is acknowledged in its first cycle with that data. Each such hit issues one further read-ahead.
- R8: After a demand read to a drive whose prefEn bit is 0, no read-ahead is issued, and the next data-port read is again a demand read.
- R9: A data-port read whose width differs from the locked read-ahead width discards the read-ahead. It is served as a demand read at its own width.
- R10: A data-port write, an unrelated access or a one-cycle pulse on stopIn discards held read-ahead data. A read-ahead already issued completes at the sequencer and is dropped, so the next data-port read is a demand read.
- R11: While seqReq is high and seqAck is low, seqReq stays high and every sequencer field stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| postEn | input | 2 | Write posting enable, one bit per drive |
| prefEn | input | 2 | Read-ahead enable, one bit per drive |
| stopIn | input | 1 | Discard read-ahead data (end of transfer) |
| hostReq | input | 1 | Host access request, held until hostAck |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostDataPort | input | 1 | 1 = data port, 0 = other task-file register |
| hostChan | input | 1 | 1 = access belongs to the other channel |
| hostWide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| hostDrive | input | 1 | Target drive |
| hostWdata | input | DATA_W | Host write data |
| hostAck | output | 1 | Access completes this cycle |
| hostRdata | output | DATA_W | Read data, valid with hostAck on a read |
| seqReq | output | 1 | Device cycle request to the sequencer |
| seqWrite | output | 1 | Device cycle is a write |
| seqDataPort | output | 1 | Device cycle targets the data port |
| seqChan | output | 1 | Device cycle belongs to the other channel |
| seqWide | output | 1 | Device cycle width, 1 = 32-bit |
| seqDrive | output | 1 | Device cycle drive |
| seqWdata | output | DATA_W | Device write data |
| seqAck | input | 1 | Sequencer completes the cycle this cycle |
| seqRdata | input | DATA_W | Device read data, valid with seqAck |

## Verification
The hardest case to reach is a read-ahead that is already issued to the sequencer when a discard arrives, because the window is only the sequencer's latency wide. The bench sets a fixed sequencer latency of four cycles. It waits one idle cycle after a demand read completes, which puts the read-ahead on the sequencer port, and then posts a write. The next read must then be a demand read that returns the newest device word and not the dropped one. The full-FIFO stall comes from five back-to-back posted writes arriving faster than the slow sequencer drains them.

// File: rtl/ataPostPkg.sv
package ataPostPkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_DRAIN = 2'd1,
    OP_PASS  = 2'd2,
    OP_PREF  = 2'd3
  } opKind_t;

  typedef struct packed {
    logic    push;
    logic    pop;
    logic    loadPref;
    logic    rdFromPref;
    opKind_t op;
  } ctlStrobe_t;

endpackage

// File: rtl/ataPostData.sv
module ataPostData
  import ataPostPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic              prefWide,
  input  logic              prefDrive,
  input  logic              hostWrite,
  input  logic              hostDataPort,
  input  logic              hostChan,
  input  logic              hostWide,
  input  logic              hostDrive,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] seqRdata,
  input  logic              seqReq,
  input  logic              seqAck,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic [DATA_W-1:0] hostRdata,
  output logic              seqWrite,
  output logic              seqDataPort,
  output logic              seqChan,
  output logic              seqWide,
  output logic              seqDrive,
  output logic [DATA_W-1:0] seqWdata
);

  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int ENTRY_W = DATA_W + 2;

  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count;
  logic [ENTRY_W-1:0] slot [DEPTH];
  logic [ENTRY_W-1:0] head;
  logic [DATA_W-1:0]  prefData;

  // one storage slot per FIFO entry: {wide, drive, data}
  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    logic [ENTRY_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (ctl.push && (wrPtr == PTR_W'(i))) begin
        slotQ <= {hostWide, hostDrive, hostWdata};
      end
    end
    assign slot[i] = slotQ;
  end

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= bump(wrPtr);
      if (ctl.pop)  rdPtr <= bump(rdPtr);
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign head      = slot[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prefData <= '0;
    end else if (ctl.loadPref) begin
      prefData <= seqRdata;
    end
  end

  assign hostRdata = ctl.rdFromPref ? prefData : seqRdata;

  always_comb begin
    seqWrite    = 1'b0;
    seqDataPort = 1'b0;
    seqChan     = 1'b0;
    seqWide     = 1'b0;
    seqDrive    = 1'b0;
    seqWdata    = '0;
    case (ctl.op)
      OP_DRAIN: begin
        seqWrite    = 1'b1;
        seqDataPort = 1'b1;
        seqWide     = head[ENTRY_W-1];
        seqDrive    = head[ENTRY_W-2];
        seqWdata    = head[DATA_W-1:0];
      end
      OP_PASS: begin
        seqWrite    = hostWrite;
        seqDataPort = hostDataPort;
        seqChan     = hostChan;
        seqWide     = hostWide;
        seqDrive    = hostDrive;
        seqWdata    = hostWdata;
      end
      OP_PREF: begin
        seqDataPort = 1'b1;
        seqWide     = prefWide;
        seqDrive    = prefDrive;
      end
      default: ;
    endcase
  end

  // R3: the control never pushes into a full FIFO
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> (count < CNT_W'(DEPTH)));

  // R5: unrelated cycles only reach the sequencer once posted data is gone
  assert_unrelated_drained_R5: assert property (@(posedge clk) disable iff (!rstN)
    (seqReq && (!seqDataPort || seqChan)) |-> (count == '0));

  // R11: sequencer fields hold while the cycle is outstanding
  assert_seq_fields_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (seqReq && !seqAck) |=> ($stable(seqWrite) && $stable(seqWide) &&
                             $stable(seqDrive) && $stable(seqWdata) &&
                             $stable(seqDataPort) && $stable(seqChan)));

endmodule

// File: rtl/ataPostCtl.sv
module ataPostCtl
  import ataPostPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] postEn,
  input  logic [1:0] prefEn,
  input  logic       stopIn,
  input  logic       hostReq,
  input  logic       hostWrite,
  input  logic       hostDataPort,
  input  logic       hostChan,
  input  logic       hostWide,
  input  logic       hostDrive,
  input  logic       seqAck,
  input  logic       fifoFull,
  input  logic       fifoEmpty,
  output ctlStrobe_t ctl,
  output logic       hostAck,
  output logic       seqReq,
  output logic       prefWide,
  output logic       prefDrive
);

  opKind_t opKind, opNext;
  logic    prefArm, prefValid;

  logic ownData, dataWr, dataRd, unrel, postOn, prefOn;
  logic hitRd, kill, push, passDone, needPass, prefWant, loadPref, arm;

  always_comb begin
    ownData  = hostDataPort && !hostChan;
    dataWr   = hostReq && ownData && hostWrite;
    dataRd   = hostReq && ownData && !hostWrite;
    unrel    = hostReq && !ownData;
    postOn   = postEn[hostDrive];
    prefOn   = prefEn[hostDrive];
    hitRd    = dataRd && prefValid && (hostWide == prefWide);
    kill     = stopIn || dataWr || unrel ||
               (dataRd && (prefValid || prefArm) && (hostWide != prefWide));
    push     = dataWr && postOn && !fifoFull;
    passDone = (opKind == OP_PASS) && seqAck;
    needPass = unrel || (dataWr && !postOn) ||
               (dataRd && !prefValid && !prefArm);
    prefWant = prefArm && !prefValid && !kill;
    loadPref = (opKind == OP_PREF) && seqAck && prefArm && !kill;
    arm      = passDone && dataRd && prefOn && !stopIn;
  end

  always_comb begin
    opNext = opKind;
    if (opKind == OP_NONE) begin
      if (!fifoEmpty)    opNext = OP_DRAIN;
      else if (prefWant) opNext = OP_PREF;
      else if (needPass) opNext = OP_PASS;
    end else if (seqAck) begin
      opNext = OP_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opKind    <= OP_NONE;
      prefArm   <= 1'b0;
      prefValid <= 1'b0;
      prefWide  <= 1'b0;
      prefDrive <= 1'b0;
    end else begin
      opKind <= opNext;
      if (kill) begin
        prefArm   <= 1'b0;
        prefValid <= 1'b0;
      end else begin
        if (arm) begin
          prefArm   <= 1'b1;
          prefWide  <= hostWide;
          prefDrive <= hostDrive;
        end
        if (loadPref)   prefValid <= 1'b1;
        else if (hitRd) prefValid <= 1'b0;
      end
    end
  end

  assign seqReq  = (opKind != OP_NONE);
  assign hostAck = push || hitRd || passDone;

  assign ctl.push       = push;
  assign ctl.pop        = (opKind == OP_DRAIN) && seqAck;
  assign ctl.loadPref   = loadPref;
  assign ctl.rdFromPref = hitRd;
  assign ctl.op         = opKind;

  // R4: unposted writes and unrelated accesses finish with the sequencer
  assert_unposted_waits_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostAck && (unrel || (dataWr && !postOn))) |-> (seqReq && seqAck));

  // R11: an outstanding sequencer request is not withdrawn
  assert_seq_req_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (seqReq && !seqAck) |=> seqReq);

endmodule

// File: rtl/ataPostBuf.sv
module ataPostBuf
  import ataPostPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        postEn,
  input  logic [1:0]        prefEn,
  input  logic              stopIn,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic              hostDataPort,
  input  logic              hostChan,
  input  logic              hostWide,
  input  logic              hostDrive,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  output logic              seqReq,
  output logic              seqWrite,
  output logic              seqDataPort,
  output logic              seqChan,
  output logic              seqWide,
  output logic              seqDrive,
  output logic [DATA_W-1:0] seqWdata,
  input  logic              seqAck,
  input  logic [DATA_W-1:0] seqRdata
);

  ctlStrobe_t ctl;
  logic       fifoFull, fifoEmpty, prefWide, prefDrive;

  ataPostCtl uCtl (
    .clk(clk), .rstN(rstN), .postEn(postEn), .prefEn(prefEn), .stopIn(stopIn),
    .hostReq(hostReq), .hostWrite(hostWrite), .hostDataPort(hostDataPort),
    .hostChan(hostChan), .hostWide(hostWide), .hostDrive(hostDrive),
    .seqAck(seqAck), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .ctl(ctl), .hostAck(hostAck), .seqReq(seqReq),
    .prefWide(prefWide), .prefDrive(prefDrive)
  );

  ataPostData #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .prefWide(prefWide), .prefDrive(prefDrive),
    .hostWrite(hostWrite), .hostDataPort(hostDataPort), .hostChan(hostChan),
    .hostWide(hostWide), .hostDrive(hostDrive), .hostWdata(hostWdata),
    .seqRdata(seqRdata), .seqReq(seqReq), .seqAck(seqAck),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .hostRdata(hostRdata),
    .seqWrite(seqWrite), .seqDataPort(seqDataPort), .seqChan(seqChan),
    .seqWide(seqWide), .seqDrive(seqDrive), .seqWdata(seqWdata)
  );

endmodule

// File: tb/ataPostBuf_test.sv
`timescale 1ns/1ps
module ataPostBuf_test;

  localparam int DATA_W = 32;
  localparam int LAT    = 4;
  localparam int LOGN   = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] postEn = 2'b00, prefEn = 2'b00;
  logic stopIn = 1'b0;
  logic hostReq = 1'b0, hostWrite = 1'b0, hostDataPort = 1'b0, hostChan = 1'b0;
  logic hostWide = 1'b0, hostDrive = 1'b0;
  logic [DATA_W-1:0] hostWdata = '0;
  logic hostAck;
  logic [DATA_W-1:0] hostRdata;
  logic seqReq, seqWrite, seqDataPort, seqChan, seqWide, seqDrive;
  logic [DATA_W-1:0] seqWdata;
  logic seqAck = 1'b0;
  logic [DATA_W-1:0] seqRdata = '0;

  always #5 clk = ~clk;

  ataPostBuf #(.DATA_W(DATA_W), .DEPTH(4)) uut (
    .clk(clk), .rstN(rstN), .postEn(postEn), .prefEn(prefEn), .stopIn(stopIn),
    .hostReq(hostReq), .hostWrite(hostWrite), .hostDataPort(hostDataPort),
    .hostChan(hostChan), .hostWide(hostWide), .hostDrive(hostDrive),
    .hostWdata(hostWdata), .hostAck(hostAck), .hostRdata(hostRdata),
    .seqReq(seqReq), .seqWrite(seqWrite), .seqDataPort(seqDataPort),
    .seqChan(seqChan), .seqWide(seqWide), .seqDrive(seqDrive),
    .seqWdata(seqWdata), .seqAck(seqAck), .seqRdata(seqRdata)
  );

  int errors = 0;
  int checks = 0;

  // sequencer model: fixed latency, distinct read words
  int cnt = 0;
  int readIdx = 0;
  always @(posedge clk) begin
    seqAck <= 1'b0;
    if (!seqReq) cnt <= 0;
    else if (!seqAck) begin
      if (cnt == LAT - 1) begin
        seqAck   <= 1'b1;
        cnt      <= 0;
        seqRdata <= 32'hA500_0000 + readIdx;
        readIdx  <= readIdx + 1;
      end else cnt <= cnt + 1;
    end
  end

  // log of completed sequencer cycles, plus field stability watch
  logic logW [LOGN];
  logic logDp [LOGN];
  logic logCh [LOGN];
  logic logWide [LOGN];
  logic logDrv [LOGN];
  logic [DATA_W-1:0] logWd [LOGN];
  logic [DATA_W-1:0] logRd [LOGN];
  int logCnt = 0;
  int stableErr = 0;
  logic pReq = 1'b0, pAck = 1'b0;
  logic [DATA_W+5:0] pFields = '0;
  always @(negedge clk) begin
    if (pReq && !pAck && rstN) begin
      if (!seqReq || pFields != {seqWrite, seqDataPort, seqChan, seqWide, seqDrive, seqWdata, 1'b0})
        stableErr++;
    end
    pReq = seqReq;
    pAck = seqAck;
    pFields = {seqWrite, seqDataPort, seqChan, seqWide, seqDrive, seqWdata, 1'b0};
    if (seqReq && seqAck && logCnt < LOGN) begin
      logW[logCnt] = seqWrite;
      logDp[logCnt] = seqDataPort;
      logCh[logCnt] = seqChan;
      logWide[logCnt] = seqWide;
      logDrv[logCnt] = seqDrive;
      logWd[logCnt] = seqWdata;
      logRd[logCnt] = seqRdata;
      logCnt++;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish (act=hung exp=done)");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hostDo(input logic w, input logic dp, input logic ch,
                        input logic wd, input logic drv, input logic [31:0] data,
                        output logic [31:0] rd, output int waited);
    @(negedge clk);
    hostReq = 1'b1; hostWrite = w; hostDataPort = dp; hostChan = ch;
    hostWide = wd; hostDrive = drv; hostWdata = data;
    waited = 0;
    #1;
    while (!hostAck) begin
      @(negedge clk);
      #1;
      waited++;
    end
    rd = hostRdata;
    @(posedge clk);
    #1;
    hostReq = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStop();
    @(negedge clk);
    stopIn = 1'b1;
    @(negedge clk);
    stopIn = 1'b0;
  endtask

  logic [31:0] rd;
  int waited;
  int n0;

  task automatic testReset();
    #1;
    chk(seqReq == 1'b0, "R1", "seqReq after reset", 32'(seqReq), 0);
    chk(hostAck == 1'b0, "R1", "hostAck after reset", 32'(hostAck), 0);
  endtask

  task automatic testPosted();
    postEn = 2'b11;
    n0 = logCnt;
    hostDo(1, 1, 0, 0, 1, 32'h0000_1111, rd, waited);
    chk(waited == 0, "R2", "posted write ack delay", 32'(waited), 0);
    idle(20);
    chk(logCnt == n0 + 1, "R2", "device writes issued", 32'(logCnt - n0), 1);
    chk(logW[n0] && logWd[n0] == 32'h1111 && !logWide[n0] && logDrv[n0],
        "R2", "device write data", logWd[n0], 32'h1111);
  endtask

  task automatic testFull();
    int w5;
    n0 = logCnt;
    for (int i = 0; i < 6; i++) begin
      hostDo(1, 1, 0, 1'(i), 1'(i >> 1), 32'h100 + i, rd, waited);
      if (i < 4) chk(waited == 0, "R3", "write into free FIFO delay", 32'(waited), 0);
      if (i == 4) w5 = waited;
    end
    chk(w5 >= 1, "R3", "fifth write stalls on full FIFO", 32'(w5), 1);
    idle(60);
    chk(logCnt == n0 + 6, "R3", "all writes drained", 32'(logCnt - n0), 6);
    for (int i = 0; i < 6; i++)
      chk(logWd[n0+i] == 32'h100 + i && logWide[n0+i] == 1'(i) && logDrv[n0+i] == 1'(i >> 1),
          "R3", "drain order", logWd[n0+i], 32'h100 + i);
  endtask

  task automatic testNoPost();
    postEn = 2'b00;
    n0 = logCnt;
    hostDo(1, 1, 0, 1, 0, 32'h0000_2222, rd, waited);
    chk(waited >= LAT, "R4", "unposted write waits for device", 32'(waited), LAT);
    chk(logCnt == n0 + 1 && logWd[n0] == 32'h2222, "R4", "device write done at ack",
        32'(logCnt - n0), 1);
    postEn = 2'b11;
  endtask

  task automatic testUnrelated();
    n0 = logCnt;
    for (int i = 0; i < 3; i++) hostDo(1, 1, 0, 0, 0, 32'h300 + i, rd, waited);
    hostDo(0, 0, 0, 0, 0, 0, rd, waited);
    chk(logCnt == n0 + 4, "R5", "register read after drain count", 32'(logCnt - n0), 4);
    chk(!logDp[n0+3] && !logW[n0+3] && logW[n0+2] && logWd[n0+2] == 32'h302,
        "R5", "register read ordered after writes", 32'(logDp[n0+3]), 0);
    n0 = logCnt;
    hostDo(1, 1, 0, 0, 0, 32'h400, rd, waited);
    hostDo(1, 1, 1, 0, 0, 32'h401, rd, waited);
    chk(logCnt == n0 + 2 && logCh[n0+1] && logWd[n0] == 32'h400,
        "R5", "other-channel write after drain", 32'(logCnt - n0), 2);
  endtask

  task automatic testPrefetch();
    prefEn = 2'b11;
    n0 = logCnt;
    hostDo(0, 1, 0, 1, 0, 0, rd, waited);
    chk(waited >= LAT, "R6", "demand read waits", 32'(waited), LAT);
    chk(rd == logRd[n0] && !logW[n0] && logWide[n0], "R6", "demand read data", rd, logRd[n0]);
    idle(30);
    chk(logCnt == n0 + 2 && !logW[n0+1] && logWide[n0+1] && !logDrv[n0+1],
        "R7", "read-ahead issued", 32'(logCnt - n0), 2);
    hostDo(0, 1, 0, 1, 0, 0, rd, waited);
    chk(waited == 0, "R7", "hit served at once", 32'(waited), 0);
    chk(rd == logRd[n0+1], "R7", "hit data", rd, logRd[n0+1]);
    idle(30);
    chk(logCnt == n0 + 3 && logWide[n0+2], "R7", "next read-ahead after hit",
        32'(logCnt - n0), 3);
  endtask

  task automatic testMismatch();
    n0 = logCnt;
    hostDo(0, 1, 0, 0, 0, 0, rd, waited);
    chk(waited >= LAT, "R9", "other width is demand", 32'(waited), LAT);
    chk(logCnt == n0 + 1 && !logWide[n0] && rd == logRd[n0], "R9", "demand at own width",
        rd, logRd[n0]);
    idle(30);
  endtask

  task automatic testKill();
    // held data killed by a posted write
    hostDo(1, 1, 0, 0, 0, 32'h500, rd, waited);
    idle(20);
    hostDo(0, 1, 0, 0, 0, 0, rd, waited);
    chk(waited >= LAT && rd == logRd[logCnt-1], "R10", "read after write is demand",
        32'(waited), LAT);
    idle(30);
    pulseStop();
    hostDo(0, 1, 0, 0, 0, 0, rd, waited);
    chk(waited >= LAT && rd == logRd[logCnt-1], "R10", "read after stop is demand",
        32'(waited), LAT);
    idle(30);
    hostDo(0, 0, 0, 0, 0, 0, rd, waited);
    hostDo(0, 1, 0, 0, 0, 0, rd, waited);
    chk(waited >= LAT && rd == logRd[logCnt-1], "R10", "read after register access is demand",
        32'(waited), LAT);
    // read-ahead in flight when a write arrives
    idle(30);
    pulseStop();
    hostDo(0, 1, 0, 0, 0, 0, rd, waited);
    n0 = logCnt;
    @(negedge clk);
    hostDo(1, 1, 0, 0, 0, 32'h600, rd, waited);
    idle(20);
    chk(logCnt == n0 + 2 && !logW[n0] && logW[n0+1], "R10", "in-flight read-ahead completes",
        32'(logCnt - n0), 2);
    hostDo(0, 1, 0, 0, 0, 0, rd, waited);
    chk(waited >= LAT && rd == logRd[logCnt-1] && rd != logRd[n0], "R10",
        "in-flight data dropped", rd, logRd[logCnt-1]);
  endtask

  task automatic testNoPref();
    pulseStop();
    idle(20);
    prefEn = 2'b01;
    n0 = logCnt;
    hostDo(0, 1, 0, 1, 1, 0, rd, waited);
    idle(30);
    chk(logCnt == n0 + 1, "R8", "no read-ahead when disabled", 32'(logCnt - n0), 1);
    hostDo(0, 1, 0, 1, 1, 0, rd, waited);
    chk(waited >= LAT, "R8", "second read is demand", 32'(waited), LAT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPosted();
    testFull();
    testNoPost();
    testUnrelated();
    testPrefetch();
    testMismatch();
    testKill();
    testNoPref();
    idle(10);
    chk(stableErr == 0, "R11", "sequencer fields held while waiting", 32'(stableErr), 0);
    summary();
    $finish;
  end

endmodule